// File: doc/BRIEF.md
# Centre-of-Gravity Slope Engine

This block turns stored wavefront-sensor pixels into local wavefront slopes, one subaperture row at a time. It runs in a slow clock domain, about one sixteenth of the pixel clock. Acquisition logic in the fast domain writes a complete row of subapertures into a two-row banked pixel memory. It then flips a toggle line. The engine passes the toggle through a synchroniser and turns each change into a one-cycle row pulse. It then walks the row in groups of `ITER` subapertures. Each group is one word read from the memory's second port, so the row it computes and the row being acquired never collide.

For every subaperture in a group the engine forms the intensity-weighted position sums along x and y, and the total intensity. Positions are measured from the subaperture centre. It then divides each sum by the total with bit-serial restoring dividers, one quotient bit per cycle, all lanes in parallel. Each group produces `ITER` x/y slope pairs in signed fixed point with `FRAC` fractional bits, marked by a one-cycle valid strobe. A running slope count lets a downstream reconstructor follow progress through the frame.

The controller has five states:
- `ST_INIT`: waiting for a row.
- `ST_FETCH`: address presented.
- `ST_LOAD`: pixel word returned; sums formed and dividers loaded.
- `ST_DIVIDE`: quotient bits produced.
- `ST_EMIT`: results published.

It has these transitions:
- INIT→FETCH on a row pulse or a remembered pending row.
- FETCH→LOAD always.
- LOAD→DIVIDE always.
- DIVIDE→EMIT after `QW` divide cycles.
- EMIT→FETCH while groups remain in the row.
- EMIT→INIT after the last group.
- Any state→INIT on `frame_start`.

Top module: `cog_slope_engine`

## Requirements
- R1: After reset `slope_valid` is 0, `pipe_out` is 0 and `rd_addr` is 0. No slope is produced until the synchronised `row_done_tgl` changes value.
- R2: Each change of `row_done_tgl` makes the engine process one subaperture row. A row yields exactly `N_SUB/ITER` group results, each marked by `slope_valid` high for exactly one cycle.
- R3: For a subaperture, pixel (row r, column c) has weights `c-(P-1)/2` for x and `r-(P-1)/2` for y. The slope is the sum of weight times intensity divided by the total intensity, scaled by 2^FRAC. It is output as a two's-complement value, truncated toward zero, and agrees with that definition to within 1 LSB.
- R4: A subaperture whose total intensity is zero yields x and y slopes of exactly 0.
- R5: Within a `rd_data` word, lane k occupies bits `[k*P*P*PIX_W +: P*P*PIX_W]`, and the pixel at (r, c) sits at pixel index `r*P+c` of its lane. Lane k's results appear at bits `[k*SLOPE_W +: SLOPE_W]` of `slope_x` and `slope_y`.
- R6: `pipe_out` rises by `ITER` with every `slope_valid` pulse and changes at no other time. A `frame_start` cycle clears it to 0.
- R7: `rd_addr` is `{row_sel, group}`. The group counts up from 0 within a row, and `row_sel` alternates between consecutive rows, starting at 0 after reset or `frame_start`.
- R8: A row toggle that arrives while a row is still being computed is remembered. That row is processed right after the current one, from the other row buffer.
- R9: After the last group of a row the engine returns to waiting and emits nothing more until the next toggle.
- R10: The magnitude of every slope is at most `(P-1)/2 * 2^FRAC`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Engine (slow) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Synchronous one-cycle frame restart; clears count and row parity |
| row_done_tgl | input | 1 | Row-complete toggle from the acquisition domain |
| rd_addr | output | 1+GRP_W | Pixel memory read address {row_sel, group} |
| rd_data | input | ITER*P*P*PIX_W | Pixel word, one cycle after the address |
| slope_x | output | ITER*SLOPE_W | Packed signed x slopes, FRAC fractional bits |
| slope_y | output | ITER*SLOPE_W | Packed signed y slopes, FRAC fractional bits |
| slope_valid | output | 1 | One-cycle strobe per completed group |
| pipe_out | output | CNT_W | Slopes completed since frame start |

## Verification
The hardest situation to bring about is a second row toggle that lands while a row is still being divided. It must be remembered, and the following row must be read from the opposite buffer. The bench preloads both row buffers with different images and toggles twice a few cycles apart. It then expects both rows, in order, each matching its own image. A 16-position single-bright-pixel sweep, pseudo-random images and an extreme one-column image cover the arithmetic across the full slope range. An odd row count before a frame restart confirms that the row parity is reset.

// File: rtl/cog_pkg.sv
package cog_pkg;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_FETCH,
        ST_LOAD,
        ST_DIVIDE,
        ST_EMIT
    } eng_state_t;

    function automatic int safe_clog2(input int v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction

endpackage

// File: rtl/cog_moments.sv
module cog_moments #(
    parameter int P     = 4,
    parameter int PIX_W = 12,
    parameter int TOT_W = 16,
    parameter int MOM_W = 19
) (
    input  logic [P*P*PIX_W-1:0]     pix,
    output logic [TOT_W-1:0]         total,
    output logic signed [MOM_W-1:0]  mom_x,
    output logic signed [MOM_W-1:0]  mom_y
);

    always_comb begin
        logic signed [MOM_W-1:0] val;
        logic signed [MOM_W-1:0] wx;
        logic signed [MOM_W-1:0] wy;
        total = '0;
        mom_x = '0;
        mom_y = '0;
        for (int r = 0; r < P; r++) begin
            for (int c = 0; c < P; c++) begin
                val   = MOM_W'(pix[(r*P+c)*PIX_W +: PIX_W]);
                wx    = MOM_W'(2*c - (P-1));
                wy    = MOM_W'(2*r - (P-1));
                total = total + TOT_W'(pix[(r*P+c)*PIX_W +: PIX_W]);
                mom_x = mom_x + wx * val;
                mom_y = mom_y + wy * val;
            end
        end
    end

endmodule

// File: rtl/cog_divider.sv
module cog_divider #(
    parameter int NW = 24,
    parameter int DW = 16,
    parameter int QW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [QW-1:0] quo
);

    logic [DW-1:0] rem_q;
    logic [QW-1:0] sh_q;
    logic [DW-1:0] den_q;
    logic [DW:0]   trial;

    assign trial = {rem_q, sh_q[QW-1]};
    assign quo   = sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            sh_q  <= '0;
            den_q <= '0;
        end else if (load) begin
            rem_q <= DW'(num >> QW);
            sh_q  <= num[QW-1:0];
            den_q <= den;
        end else if (step) begin
            if (trial >= {1'b0, den_q}) begin
                rem_q <= DW'(trial - {1'b0, den_q});
                sh_q  <= {sh_q[QW-2:0], 1'b1};
            end else begin
                rem_q <= trial[DW-1:0];
                sh_q  <= {sh_q[QW-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/cog_slope_engine.sv
module cog_slope_engine
    import cog_pkg::*;
#(
    parameter int P     = 4,
    parameter int ITER  = 2,
    parameter int N_SUB = 8,
    parameter int PIX_W = 12,
    parameter int FRAC  = 8,
    parameter int CNT_W = 16,
    localparam int NPIX    = P*P,
    localparam int SUB_W   = NPIX*PIX_W,
    localparam int GROUPS  = N_SUB/ITER,
    localparam int GRP_W   = safe_clog2(GROUPS),
    localparam int ADDR_W  = GRP_W + 1,
    localparam int POS_W   = safe_clog2(P),
    localparam int QW      = POS_W + FRAC,
    localparam int SLOPE_W = QW + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_start,
    input  logic                     row_done_tgl,
    output logic [ADDR_W-1:0]        rd_addr,
    input  logic [ITER*SUB_W-1:0]    rd_data,
    output logic [ITER*SLOPE_W-1:0]  slope_x,
    output logic [ITER*SLOPE_W-1:0]  slope_y,
    output logic                     slope_valid,
    output logic [CNT_W-1:0]         pipe_out
);

    localparam int TOT_W = PIX_W + $clog2(NPIX);
    localparam int MAG_W = TOT_W + POS_W;
    localparam int MOM_W = MAG_W + 1;
    localparam int NW    = MAG_W + FRAC - 1;
    localparam int DCW   = safe_clog2(QW + 1);

    eng_state_t        state, state_nxt;
    logic [2:0]        tgl_sync;
    logic              row_pulse;
    logic              pending_q;
    logic [GRP_W-1:0]  grp_q;
    logic              row_sel_q;
    logic [DCW-1:0]    div_cnt_q;
    logic              valid_q;
    logic [CNT_W-1:0]  pipe_q;
    logic              last_grp;
    logic              div_done;
    logic              row_go;

    // Row-complete toggle synchroniser and change detector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tgl_sync <= '0;
        else        tgl_sync <= {tgl_sync[1:0], row_done_tgl};
    end
    assign row_pulse = tgl_sync[2] ^ tgl_sync[1];

    assign last_grp = (grp_q == GRP_W'(GROUPS-1));
    assign div_done = (div_cnt_q == DCW'(QW-1));
    assign row_go   = row_pulse | pending_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_INIT;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_INIT:   if (row_go) state_nxt = ST_FETCH;
            ST_FETCH:  state_nxt = ST_LOAD;
            ST_LOAD:   state_nxt = ST_DIVIDE;
            ST_DIVIDE: if (div_done) state_nxt = ST_EMIT;
            ST_EMIT:   state_nxt = last_grp ? ST_INIT : ST_FETCH;
            default:   state_nxt = ST_INIT;
        endcase
        if (frame_start) state_nxt = ST_INIT;
    end

    // Control counters and output strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            grp_q     <= '0;
            row_sel_q <= 1'b0;
            div_cnt_q <= '0;
            valid_q   <= 1'b0;
            pipe_q    <= '0;
        end else if (frame_start) begin
            pending_q <= 1'b0;
            grp_q     <= '0;
            row_sel_q <= 1'b0;
            div_cnt_q <= '0;
            valid_q   <= 1'b0;
            pipe_q    <= '0;
        end else begin
            valid_q <= 1'b0;
            if (state == ST_INIT) pending_q <= 1'b0;
            else                  pending_q <= pending_q | row_pulse;
            unique case (state)
                ST_LOAD:   div_cnt_q <= '0;
                ST_DIVIDE: div_cnt_q <= div_cnt_q + 1'b1;
                ST_EMIT: begin
                    valid_q <= 1'b1;
                    pipe_q  <= pipe_q + CNT_W'(ITER);
                    if (last_grp) begin
                        grp_q     <= '0;
                        row_sel_q <= ~row_sel_q;
                    end else begin
                        grp_q <= grp_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign rd_addr     = {row_sel_q, grp_q};
    assign slope_valid = valid_q;
    assign pipe_out    = pipe_q;

    // One datapath lane per subaperture of a group
    for (genvar k = 0; k < ITER; k++) begin : g_lane
        logic [TOT_W-1:0]         total;
        logic signed [MOM_W-1:0]  mom_x, mom_y;
        logic [MAG_W-1:0]         mag_x, mag_y;
        logic [QW-1:0]            quo_x, quo_y;
        logic                     zero_q, neg_x_q, neg_y_q;
        logic [SLOPE_W-1:0]       sx_q, sy_q;

        cog_moments #(
            .P(P), .PIX_W(PIX_W), .TOT_W(TOT_W), .MOM_W(MOM_W)
        ) mom_i (
            .pix   (rd_data[k*SUB_W +: SUB_W]),
            .total (total),
            .mom_x (mom_x),
            .mom_y (mom_y)
        );

        assign mag_x = mom_x[MOM_W-1] ? MAG_W'(-mom_x) : MAG_W'(mom_x);
        assign mag_y = mom_y[MOM_W-1] ? MAG_W'(-mom_y) : MAG_W'(mom_y);

        cog_divider #(.NW(NW), .DW(TOT_W), .QW(QW)) divx_i (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (state == ST_LOAD),
            .step  (state == ST_DIVIDE),
            .num   (NW'(mag_x) << (FRAC-1)),
            .den   (total),
            .quo   (quo_x)
        );

        cog_divider #(.NW(NW), .DW(TOT_W), .QW(QW)) divy_i (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (state == ST_LOAD),
            .step  (state == ST_DIVIDE),
            .num   (NW'(mag_y) << (FRAC-1)),
            .den   (total),
            .quo   (quo_y)
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                zero_q  <= 1'b0;
                neg_x_q <= 1'b0;
                neg_y_q <= 1'b0;
                sx_q    <= '0;
                sy_q    <= '0;
            end else begin
                if (state == ST_LOAD) begin
                    zero_q  <= (total == '0);
                    neg_x_q <= mom_x[MOM_W-1];
                    neg_y_q <= mom_y[MOM_W-1];
                end
                if (state == ST_EMIT && !frame_start) begin
                    if (zero_q) begin
                        sx_q <= '0;
                        sy_q <= '0;
                    end else begin
                        sx_q <= neg_x_q ? -SLOPE_W'(quo_x) : SLOPE_W'(quo_x);
                        sy_q <= neg_y_q ? -SLOPE_W'(quo_y) : SLOPE_W'(quo_y);
                    end
                end
            end
        end

        assign slope_x[k*SLOPE_W +: SLOPE_W] = sx_q;
        assign slope_y[k*SLOPE_W +: SLOPE_W] = sy_q;
    end

endmodule

// File: rtl/cog_slope_engine_chk.sv
module cog_slope_engine_chk #(
    parameter int P       = 4,
    parameter int ITER    = 2,
    parameter int FRAC    = 8,
    parameter int CNT_W   = 16,
    parameter int SLOPE_W = 11,
    parameter int ADDR_W  = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    frame_start,
    input logic [ADDR_W-1:0]       rd_addr,
    input logic [ITER*SLOPE_W-1:0] slope_x,
    input logic [ITER*SLOPE_W-1:0] slope_y,
    input logic                    slope_valid,
    input logic [CNT_W-1:0]        pipe_out
);

    localparam int LIM = (P-1) * (1 << (FRAC-1));

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slope_valid |=> !slope_valid);

    // R6
    pipe_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_out != $past(pipe_out)) |-> (slope_valid || $past(frame_start)));

    // R6
    pipe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (pipe_out == '0));

    // R7
    addr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr != $past(rd_addr)) |-> (slope_valid || $past(frame_start)));

    for (genvar k = 0; k < ITER; k++) begin : g_bound
        // R10
        slope_x_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            slope_valid |-> ($signed(slope_x[k*SLOPE_W +: SLOPE_W]) <= LIM &&
                             $signed(slope_x[k*SLOPE_W +: SLOPE_W]) >= -LIM));
        // R10
        slope_y_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            slope_valid |-> ($signed(slope_y[k*SLOPE_W +: SLOPE_W]) <= LIM &&
                             $signed(slope_y[k*SLOPE_W +: SLOPE_W]) >= -LIM));
    end

endmodule

bind cog_slope_engine cog_slope_engine_chk #(
    .P(P), .ITER(ITER), .FRAC(FRAC), .CNT_W(CNT_W),
    .SLOPE_W(SLOPE_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .rd_addr     (rd_addr),
    .slope_x     (slope_x),
    .slope_y     (slope_y),
    .slope_valid (slope_valid),
    .pipe_out    (pipe_out)
);

// File: tb/cog_slope_engine_tb_top.sv
`timescale 1ns/1ps
module cog_slope_engine_tb_top;

    localparam int P      = 4;
    localparam int ITER   = 2;
    localparam int N_SUB  = 4;
    localparam int PIX_W  = 8;
    localparam int FRAC   = 8;
    localparam int CNT_W  = 16;
    localparam int NPIX   = P*P;
    localparam int SUB_W  = NPIX*PIX_W;
    localparam int GROUPS = N_SUB/ITER;
    localparam int SW     = 2 + FRAC + 1;
    localparam int AW     = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic row_done_tgl = 1'b0;
    logic [AW-1:0] rd_addr;
    logic [ITER*SUB_W-1:0] rd_data;
    logic [ITER*SW-1:0] slope_x, slope_y;
    logic slope_valid;
    logic [CNT_W-1:0] pipe_out;

    logic [ITER*SUB_W-1:0] mem [2*GROUPS];

    int checks = 0;
    int failures = 0;
    int vcount = 0;
    int exp_pipe = 0;
    int buf_sel = 0;
    int img [2][N_SUB][NPIX];
    int unsigned seed = 32'h1234_5678;

    always #4 clk = ~clk;

    always_ff @(posedge clk) rd_data <= mem[rd_addr];
    always @(negedge clk) if (slope_valid) vcount++;

    cog_slope_engine #(
        .P(P), .ITER(ITER), .N_SUB(N_SUB), .PIX_W(PIX_W),
        .FRAC(FRAC), .CNT_W(CNT_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .row_done_tgl(row_done_tgl), .rd_addr(rd_addr), .rd_data(rd_data),
        .slope_x(slope_x), .slope_y(slope_y), .slope_valid(slope_valid),
        .pipe_out(pipe_out)
    );

    function automatic int exp_slope(int slot, int sub, bit axis_y);
        int tot = 0, m = 0, w, mag;
        for (int r = 0; r < P; r++)
            for (int c = 0; c < P; c++) begin
                w = axis_y ? (2*r - (P-1)) : (2*c - (P-1));
                tot += img[slot][sub][r*P+c];
                m += w * img[slot][sub][r*P+c];
            end
        if (tot == 0) return 0;
        mag = ((m < 0) ? -m : m) * (1 << (FRAC-1)) / tot;
        return (m < 0) ? -mag : mag;
    endfunction

    task automatic check_near(string req, int act, int exp_v, int tol);
        int d = act - exp_v;
        checks++;
        if (d > tol || d < -tol) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic load_slot(int slot, int b);
        for (int sub = 0; sub < N_SUB; sub++)
            for (int i = 0; i < NPIX; i++)
                mem[b*GROUPS + sub/ITER][((sub%ITER)*NPIX + i)*PIX_W +: PIX_W] =
                    PIX_W'(img[slot][sub][i]);
    endtask

    task automatic collect(int slot, string req);
        int sub, to;
        for (int g = 0; g < GROUPS; g++) begin
            to = 0;
            @(negedge clk);
            while (!slope_valid && to < 400) begin
                @(negedge clk);
                to++;
            end
            if (!slope_valid) begin
                checks++; failures++;
                $display("FAIL R2 no slope_valid actual=0 expected=1");
                return;
            end
            for (int k = 0; k < ITER; k++) begin
                sub = g*ITER + k;
                // R3 R4 R5 R7 via per-lane values
                check_near({req, " x"}, int'($signed(slope_x[k*SW +: SW])),
                           exp_slope(slot, sub, 1'b0), 1);
                check_near({req, " y"}, int'($signed(slope_y[k*SW +: SW])),
                           exp_slope(slot, sub, 1'b1), 1);
            end
            exp_pipe += ITER;
            check_near("R6 pipe_out", int'(pipe_out), exp_pipe, 0);
            @(negedge clk);
            check_near("R2 one-cycle valid", int'(slope_valid), 0, 0);
        end
    endtask

    task automatic run_row(int slot, string req);
        load_slot(slot, buf_sel);
        @(negedge clk) row_done_tgl = ~row_done_tgl;
        collect(slot, req);
        buf_sel ^= 1;
    endtask

    function automatic int lcg();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'hFF);
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        int snap;
        for (int a = 0; a < 2*GROUPS; a++) mem[a] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_near("R1 slope_valid", int'(slope_valid), 0, 0);
        check_near("R1 pipe_out", int'(pipe_out), 0, 0);
        check_near("R1 rd_addr", int'(rd_addr), 0, 0);
        repeat (30) @(negedge clk);
        check_near("R1 no slope without toggle", vcount, 0, 0);

        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;

        // R3 uniform spots give zero
        for (int s = 0; s < N_SUB; s++)
            for (int i = 0; i < NPIX; i++) img[0][s][i] = 100 + 20*s;
        run_row(0, "R3 uniform");

        // R4 zero-intensity subaperture beside lit ones
        for (int s = 0; s < N_SUB; s++)
            for (int i = 0; i < NPIX; i++) img[0][s][i] = (s == 0) ? 0 : (i*7 + s) % 256;
        run_row(0, "R4 zero total");

        // R3 R5 sweep of single bright pixel over every position, per lane
        for (int pos = 0; pos < NPIX; pos++) begin
            for (int s = 0; s < N_SUB; s++)
                for (int i = 0; i < NPIX; i++) img[0][s][i] = 0;
            img[0][0][pos] = 200;
            img[0][1][NPIX-1-pos] = 1;
            img[0][2][pos] = 255;
            img[0][2][(pos+5)%NPIX] = 60;
            img[0][3][(pos*3)%NPIX] = 9;
            img[0][3][(pos*7+1)%NPIX] = 250;
            run_row(0, "R5 sweep");
        end

        // R3 pseudo-random images
        for (int n = 0; n < 9; n++) begin
            for (int s = 0; s < N_SUB; s++)
                for (int i = 0; i < NPIX; i++) img[0][s][i] = lcg();
            run_row(0, "R3 random");
        end

        // R10 extreme: light only in one edge column / row
        for (int s = 0; s < N_SUB; s++)
            for (int i = 0; i < NPIX; i++)
                img[0][s][i] = (s < 2) ? (((i % P) == 0) ? 255 : 0)
                                       : (((i / P) == P-1) ? 255 : 0);
        run_row(0, "R10 extreme");

        // R8 second toggle while first row computes
        for (int s = 0; s < N_SUB; s++)
            for (int i = 0; i < NPIX; i++) begin
                img[0][s][i] = lcg();
                img[1][s][i] = (i == s) ? 180 : 3;
            end
        load_slot(0, buf_sel);
        load_slot(1, buf_sel ^ 1);
        @(negedge clk) row_done_tgl = ~row_done_tgl;
        repeat (6) @(negedge clk);
        row_done_tgl = ~row_done_tgl;
        collect(0, "R8 first row");
        buf_sel ^= 1;
        collect(1, "R8 pending row");
        buf_sel ^= 1;

        // R9 idle after the row
        snap = vcount;
        repeat (80) @(negedge clk);
        check_near("R9 idle after row", vcount, snap, 0);

        // extra row so that row parity is odd before the restart
        for (int s = 0; s < N_SUB; s++)
            for (int i = 0; i < NPIX; i++) img[0][s][i] = lcg();
        run_row(0, "R3 parity row");

        // R6 R7 frame restart clears count and parity
        for (int s = 0; s < N_SUB; s++)
            for (int i = 0; i < NPIX; i++) img[1][s][i] = 0;
        load_slot(1, 1);
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        check_near("R6 pipe_out cleared", int'(pipe_out), 0, 0);
        check_near("R7 rd_addr cleared", int'(rd_addr), 0, 0);
        exp_pipe = 0;
        buf_sel = 0;
        for (int s = 0; s < N_SUB; s++)
            for (int i = 0; i < NPIX; i++) img[0][s][i] = (i < P) ? 40 + s : 0;
        run_row(0, "R7 restart buffer");

        summary();
    end

endmodule